// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block watches every cycle on a processor's internal bus and raises a debug break request when a cycle meets a programmed condition. There are two channels, A and B. Each channel compares the bus address against a stored address under a bit mask. It also qualifies the hit by several fields of the cycle: which bus carried it, whether it was an instruction fetch or a data access, its direction, and its access size. Channel B can also compare the bus data against a stored value under a data mask.

A mode bit chooses how the channels combine. In independent mode either channel breaks on its own. In sequential mode channel A only arms the unit, and the break comes from the next channel-B hit. The request is a one-cycle pulse. A flag beside it tells the exception logic whether to take the break before or after the instruction executes. Sticky per-channel status bits record which channel caused a break until software clears them. Configuration is loaded through simple register writes.

Top module: `bus_break_unit`

## Requirements
- R1: A channel's address compare passes when `((busAddr ^ addr) & ~mask) == 0`. A mask bit of 1 excludes that address bit, and an all-zero mask demands an exact match.
- R2: The condition word (config offsets 2 for A, 6 for B) uses the following cycle and direction bits. Bit 0 allows fetch cycles and bit 1 allows data cycles. Bit 2 allows reads and bit 3 allows writes. A cycle matches only if both its kind bit and its direction bit are set.
- R3: Condition bits [5:4] select the size: 00 means size is not compared, and 01 byte, 10 word and 11 long must equal `busSize`.
- R4: Condition bit 6 must equal `busSel`, so that only cycles on the selected bus can match.
- R5: A fetch cycle that is marked write, or that has an odd address, never matches on either channel, whatever the condition or mask.
- R6: When channel B condition bit 8 is set, B also needs `((busData ^ data) & ~dmask) == 0`, with data at offset 8 and data mask at offset 9. A data-mask bit of 1 excludes that bit. With bit 8 clear, data is ignored.
- R7: With mode register (offset 12) bit 0 clear, a hit on either channel raises a break.
- R8: With mode bit 0 set, a hit on A alone or on B alone (unarmed) raises no break. A B hit after an earlier A hit raises one break and disarms the unit.
- R9: Any configuration write disarms the sequential state.
- R10: `brkReq` is high for exactly the one cycle following a matching bus cycle. It is never raised for a cycle with `busValid` low.
- R11: `brkAfter` is set for a data-cycle break, and for a fetch break only if the causing channel's condition bit 7 is set. When both channels hit at once, the flag is set only if both ask for it.
- R12: `stsA`/`stsB` are set together with a break that the channel caused (a sequential break sets both). They hold until `stsClr`, and a new cause wins over a clear in the same cycle.
- R13: After reset, every register is zero: no condition can match, `brkReq` and both status bits are low, and the mode is independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration register offset |
| cfgData | input | CW (32) | Configuration write data |
| busValid | input | 1 | A bus cycle is present this clock |
| busSel | input | 1 | Which bus carries the cycle |
| busFetch | input | 1 | 1 for instruction fetch, 0 for data access |
| busWrite | input | 1 | 1 for write, 0 for read |
| busSize | input | 2 | 01 byte, 10 word, 11 long |
| busAddr | input | AW (32) | Cycle address |
| busData | input | DW (32) | Cycle data |
| stsClr | input | 1 | Clears both status bits |
| brkReq | output | 1 | One-cycle break request |
| brkAfter | output | 1 | Take break after instruction execution |
| stsA | output | 1 | Sticky: channel A caused a break |
| stsB | output | 1 | Sticky: channel B caused a break |

## Verification
The bench sweeps channel A's condition word through all 256 values against every bus-select, kind, direction and size combination. A misdecoded qualifier bit shows up there as a break that is missing or one that should not be there. Masked address and data sweeps expose an inverted mask sense, which would break on bits that should be ignored. Fetches marked write and fetches at odd addresses are driven with conditions that would otherwise hit, so a design that trusts the condition alone would break on them. The sequential cases cover an unarmed B hit and an A hit alone, B breaking only once after arming, and a configuration write between A and B. A design that forgot to disarm would break twice or break across a reprogramming.

// File: rtl/bbk_pkg.sv
package bbk_pkg;
  localparam int COND_W = 9;

  // load strobes issued by control to the datapath registers
  typedef struct packed {
    logic [1:0] ldAddr;
    logic [1:0] ldMask;
    logic [1:0] ldCond;
    logic       ldData;
    logic       ldDmask;
  } loadStrb_t;
endpackage

// File: rtl/bbk_chan_match.sv
module bbk_chan_match #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter bit HAS_DATA = 1'b0,
  parameter int CWID = 9
) (
  input  logic [AW-1:0]   refAddr,
  input  logic [AW-1:0]   refMask,
  input  logic [CWID-1:0] cond,
  input  logic [DW-1:0]   refData,
  input  logic [DW-1:0]   refDmask,
  input  logic            busValid,
  input  logic            busSel,
  input  logic            busFetch,
  input  logic            busWrite,
  input  logic [1:0]      busSize,
  input  logic [AW-1:0]   busAddr,
  input  logic [DW-1:0]   busData,
  output logic            hit,
  output logic            wantAfter
);
  logic kindOk, dirOk, sizeOk, selOk, fetchLegal, addrOk, dataHit, dataOk;

  always_comb begin
    kindOk     = busFetch ? cond[0] : cond[1];
    dirOk      = busWrite ? cond[3] : cond[2];
    sizeOk     = (cond[5:4] == 2'b00) || (cond[5:4] == busSize);
    selOk      = (cond[6] == busSel);
    fetchLegal = !busFetch || (!busWrite && !busAddr[0]);
    addrOk     = ((busAddr ^ refAddr) & ~refMask) == '0;
    dataHit    = ((busData ^ refData) & ~refDmask) == '0;
    dataOk     = !HAS_DATA || !cond[8] || dataHit;
    hit        = busValid && kindOk && dirOk && sizeOk && selOk &&
                 fetchLegal && addrOk && dataOk;
    wantAfter  = busFetch ? cond[7] : 1'b1;
  end
endmodule

// File: rtl/bbk_datapath.sv
module bbk_datapath import bbk_pkg::*; #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  loadStrb_t     strb,
  input  logic [CW-1:0] cfgData,
  input  logic          busValid,
  input  logic          busSel,
  input  logic          busFetch,
  input  logic          busWrite,
  input  logic [1:0]    busSize,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busData,
  output logic [1:0]    chHit,
  output logic [1:0]    chAfter
);
  localparam int NCH = 2;
  logic [DW-1:0] dataR, dmaskR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataR  <= '0;
      dmaskR <= '0;
    end else begin
      if (strb.ldData)  dataR  <= cfgData[DW-1:0];
      if (strb.ldDmask) dmaskR <= cfgData[DW-1:0];
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [AW-1:0]     addrR, maskR;
    logic [COND_W-1:0] condR;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        addrR <= '0;
        maskR <= '0;
        condR <= '0;
      end else begin
        if (strb.ldAddr[ch]) addrR <= cfgData[AW-1:0];
        if (strb.ldMask[ch]) maskR <= cfgData[AW-1:0];
        if (strb.ldCond[ch]) condR <= cfgData[COND_W-1:0];
      end
    end

    bbk_chan_match #(
      .AW(AW), .DW(DW), .HAS_DATA(ch == 1), .CWID(COND_W)
    ) u_match (
      .refAddr(addrR), .refMask(maskR), .cond(condR),
      .refData(dataR), .refDmask(dmaskR),
      .busValid(busValid), .busSel(busSel), .busFetch(busFetch),
      .busWrite(busWrite), .busSize(busSize), .busAddr(busAddr),
      .busData(busData), .hit(chHit[ch]), .wantAfter(chAfter[ch])
    );
  end
endmodule

// File: rtl/bbk_control.sv
module bbk_control import bbk_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic [3:0] cfgAddr,
  input  logic       cfgBit0,
  input  logic       stsClr,
  input  logic [1:0] chHit,
  input  logic [1:0] chAfter,
  output loadStrb_t  strb,
  output logic       modeSeq,
  output logic       armed,
  output logic       brkReq,
  output logic       brkAfter,
  output logic       stsA,
  output logic       stsB
);
  logic ldMode, fire, fireAfter, causeA, causeB, armedNext;

  always_comb begin
    strb   = '0;
    ldMode = 1'b0;
    if (cfgWe) begin
      case (cfgAddr)
        4'd0:    strb.ldAddr[0] = 1'b1;
        4'd1:    strb.ldMask[0] = 1'b1;
        4'd2:    strb.ldCond[0] = 1'b1;
        4'd4:    strb.ldAddr[1] = 1'b1;
        4'd5:    strb.ldMask[1] = 1'b1;
        4'd6:    strb.ldCond[1] = 1'b1;
        4'd8:    strb.ldData    = 1'b1;
        4'd9:    strb.ldDmask   = 1'b1;
        4'd12:   ldMode         = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    if (modeSeq) begin
      fire      = chHit[1] && armed;
      causeA    = fire;
      causeB    = fire;
      fireAfter = chAfter[1];
      armedNext = armed;
      if (fire)          armedNext = 1'b0;
      else if (chHit[0]) armedNext = 1'b1;
    end else begin
      fire      = |chHit;
      causeA    = chHit[0];
      causeB    = chHit[1];
      fireAfter = (!chHit[0] || chAfter[0]) && (!chHit[1] || chAfter[1]);
      armedNext = 1'b0;
    end
    if (cfgWe) armedNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeSeq  <= 1'b0;
      armed    <= 1'b0;
      brkReq   <= 1'b0;
      brkAfter <= 1'b0;
      stsA     <= 1'b0;
      stsB     <= 1'b0;
    end else begin
      if (ldMode) modeSeq <= cfgBit0;
      armed    <= armedNext;
      brkReq   <= fire;
      brkAfter <= fire && fireAfter;
      stsA     <= causeA || (stsA && !stsClr);
      stsB     <= causeB || (stsB && !stsClr);
    end
  end
endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit import bbk_pkg::*; #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = (AW > DW) ? AW : DW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [3:0]    cfgAddr,
  input  logic [CW-1:0] cfgData,
  input  logic          busValid,
  input  logic          busSel,
  input  logic          busFetch,
  input  logic          busWrite,
  input  logic [1:0]    busSize,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busData,
  input  logic          stsClr,
  output logic          brkReq,
  output logic          brkAfter,
  output logic          stsA,
  output logic          stsB
);
  loadStrb_t  strb;
  logic [1:0] chHit, chAfter;
  logic       modeSeq, armed;

  bbk_control u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgBit0(cfgData[0]), .stsClr(stsClr), .chHit(chHit), .chAfter(chAfter),
    .strb(strb), .modeSeq(modeSeq), .armed(armed), .brkReq(brkReq),
    .brkAfter(brkAfter), .stsA(stsA), .stsB(stsB)
  );

  bbk_datapath #(.AW(AW), .DW(DW), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgData(cfgData),
    .busValid(busValid), .busSel(busSel), .busFetch(busFetch),
    .busWrite(busWrite), .busSize(busSize), .busAddr(busAddr),
    .busData(busData), .chHit(chHit), .chAfter(chAfter)
  );
endmodule

// File: rtl/bbk_checker.sv
module bbk_checker (
  input logic clk,
  input logic rstN,
  input logic cfgWe,
  input logic busValid,
  input logic busFetch,
  input logic busWrite,
  input logic busAddr0,
  input logic stsClr,
  input logic modeSeq,
  input logic armed,
  input logic brkReq,
  input logic stsA,
  input logic stsB
);
  assert_no_idle_break_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> !brkReq);

  assert_bad_fetch_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busFetch && (busWrite || busAddr0)) |=> !brkReq);

  assert_seq_needs_arm_R8: assert property (@(posedge clk) disable iff (!rstN)
    (modeSeq && !armed) |=> !brkReq);

  assert_cfg_disarms_R9: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> !armed);

  assert_indep_unarmed_R7: assert property (@(posedge clk) disable iff (!rstN)
    !modeSeq |=> !armed);

  assert_sts_rise_a_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stsA) |-> brkReq);

  assert_sts_rise_b_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stsB) |-> brkReq);

  assert_sts_fall_R12: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(stsA) || $fell(stsB)) |-> $past(stsClr));
endmodule

bind bus_break_unit bbk_checker u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .busValid(busValid),
  .busFetch(busFetch), .busWrite(busWrite), .busAddr0(busAddr[0]),
  .stsClr(stsClr), .modeSeq(modeSeq), .armed(armed), .brkReq(brkReq),
  .stsA(stsA), .stsB(stsB)
);

// File: tb/bus_break_unit_tb.sv
module bus_break_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic        busValid = 1'b0, busSel = 1'b0, busFetch = 1'b0, busWrite = 1'b0;
  logic [1:0]  busSize = 2'b00;
  logic [31:0] busAddr = '0, busData = '0;
  logic        stsClr = 1'b0;
  logic        brkReq, brkAfter, stsA, stsB;
  int          errs = 0, total = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  bus_break_unit u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .busValid(busValid), .busSel(busSel), .busFetch(busFetch), .busWrite(busWrite),
    .busSize(busSize), .busAddr(busAddr), .busData(busData), .stsClr(stsClr),
    .brkReq(brkReq), .brkAfter(brkAfter), .stsA(stsA), .stsB(stsB)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // drives one bus cycle; returns after sampling the registered result
  task automatic cyc(input bit sel, input bit fetch, input bit write,
                     input logic [1:0] size, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busSel = sel; busFetch = fetch; busWrite = write;
    busSize = size; busAddr = a; busData = d;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic clrSts();
    @(negedge clk);
    stsClr = 1'b1;
    @(negedge clk);
    stsClr = 1'b0;
  endtask

  function automatic bit qualHit(input logic [8:0] c, input bit sel, input bit fetch,
                                 input bit write, input logic [1:0] size, input logic [31:0] a);
    if (fetch && (write || a[0])) return 1'b0;
    if (!(fetch ? c[0] : c[1])) return 1'b0;
    if (!(write ? c[3] : c[2])) return 1'b0;
    if (c[5:4] != 2'b00 && c[5:4] != size) return 1'b0;
    if (c[6] != sel) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; total++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R13: reset state
    chk("R13 brkReq", brkReq, 0);
    chk("R13 stsA", stsA, 0);
    chk("R13 stsB", stsB, 0);
    @(negedge clk);
    rstN = 1'b1;
    // R13: zeroed conditions never match
    cyc(0, 0, 0, 2'b11, 32'h0, 32'h0);
    chk("R13 no match after reset", brkReq, 0);
    idle();

    // R2/R3/R4/R11: sweep of channel A condition word against all cycle shapes
    wr(4'd0, 32'h0000_1000);
    for (int c = 0; c < 256; c++) begin
      wr(4'd2, c);
      for (int sel = 0; sel < 2; sel++)
        for (int f = 0; f < 2; f++)
          for (int w = 0; w < 2; w++)
            for (int s = 1; s < 4; s++) begin
              bit m;
              m = qualHit(9'(c), sel[0], f[0], w[0], 2'(s), 32'h1000);
              cyc(sel[0], f[0], w[0], 2'(s), 32'h1000, 32'h0);
              chk("R2/R3/R4 qualifier hit", brkReq, m);
              if (m) chk("R11 after flag", brkAfter, f[0] ? c[7] : 1'b1);
            end
    end
    idle();

    // R1: masked address compare (data read, any size)
    wr(4'd2, 32'h0000_000E);
    wr(4'd0, 32'h0000_1234);
    wr(4'd1, 32'h0000_00F0);
    for (int i = 0; i < 256; i++) begin
      logic [31:0] a;
      a = 32'h1234 ^ (32'(i) << 2);
      cyc(0, 0, 0, 2'b10, a, 0);
      chk("R1 masked address", brkReq, ((a ^ 32'h1234) & ~32'h00F0) == 0);
    end
    wr(4'd1, 32'h0);
    cyc(0, 0, 0, 2'b10, 32'h1234, 0);
    chk("R1 exact address hit", brkReq, 1);
    cyc(0, 0, 0, 2'b10, 32'h1235, 0);
    chk("R1 exact address miss", brkReq, 0);
    idle();
    // R10: no break without busValid, pulse ends
    @(posedge clk); #1;
    chk("R10 pulse is one cycle", brkReq, 0);
    @(negedge clk);
    busValid = 1'b0; busAddr = 32'h1234; busFetch = 1'b0;
    @(posedge clk); #1;
    chk("R10 idle bus no break", brkReq, 0);

    // R5: illegal fetches never match
    wr(4'd2, 32'h0000_000D);
    wr(4'd0, 32'h0000_1235);
    cyc(0, 1, 0, 2'b10, 32'h1235, 0);
    chk("R5 odd fetch", brkReq, 0);
    wr(4'd1, 32'h0000_0001);
    cyc(0, 1, 0, 2'b10, 32'h1235, 0);
    chk("R5 odd fetch masked", brkReq, 0);
    cyc(0, 1, 1, 2'b10, 32'h1234, 0);
    chk("R5 fetch write", brkReq, 0);
    cyc(0, 1, 0, 2'b10, 32'h1234, 0);
    chk("R5 legal fetch", brkReq, 1);
    wr(4'd2, 32'h0000_000E);
    cyc(0, 0, 1, 2'b01, 32'h1235, 0);
    chk("R5 odd data allowed", brkReq, 1);
    idle();

    // R6: channel B data compare
    wr(4'd2, 32'h0);
    wr(4'd4, 32'h0000_2000);
    wr(4'd5, 32'h0);
    wr(4'd8, 32'hA5A5_0000);
    wr(4'd9, 32'h0000_FFFF);
    wr(4'd6, 32'h0000_010E);
    for (int i = 0; i < 64; i++) begin
      logic [31:0] d;
      d = 32'hA5A5_0000 ^ (32'(i) << 13);
      cyc(0, 0, 1, 2'b11, 32'h2000, d);
      chk("R6 masked data", brkReq, ((d ^ 32'hA5A5_0000) & ~32'h0000_FFFF) == 0);
    end
    wr(4'd6, 32'h0000_000E);
    cyc(0, 0, 1, 2'b11, 32'h2000, 32'h1234_5678);
    chk("R6 data ignored when disabled", brkReq, 1);
    idle();

    // R7/R12: independent mode, status bits
    clrSts();
    #1;
    chk("R12 cleared A", stsA, 0);
    chk("R12 cleared B", stsB, 0);
    wr(4'd0, 32'h0000_3000);
    wr(4'd1, 32'h0);
    wr(4'd2, 32'h0000_008D);  // fetch, after execution
    wr(4'd6, 32'h0000_000D);  // fetch, before execution
    cyc(0, 1, 0, 2'b10, 32'h3000, 0);
    chk("R7 A alone breaks", brkReq, 1);
    chk("R11 A after", brkAfter, 1);
    chk("R12 stsA set", stsA, 1);
    chk("R12 stsB clear", stsB, 0);
    idle();
    @(posedge clk); #1;
    chk("R12 stsA sticky", stsA, 1);
    cyc(0, 1, 0, 2'b10, 32'h2000, 0);
    chk("R7 B alone breaks", brkReq, 1);
    chk("R11 B before", brkAfter, 0);
    chk("R12 stsB set", stsB, 1);
    idle();
    // R12: set wins over clear
    @(negedge clk);
    busValid = 1'b1; busFetch = 1'b1; busWrite = 1'b0; busAddr = 32'h3000; stsClr = 1'b1;
    @(posedge clk); #1;
    chk("R12 set wins A", stsA, 1);
    chk("R12 clear B", stsB, 0);
    @(negedge clk);
    busValid = 1'b0; stsClr = 1'b0;
    // R11: both hit, one before -> before
    wr(4'd4, 32'h0000_3000);
    cyc(0, 1, 0, 2'b10, 32'h3000, 0);
    chk("R11 both hit mixed", brkAfter, 0);
    chk("R7 both hit", brkReq, 1);
    idle();

    // R8/R9: sequential mode
    wr(4'd4, 32'h0000_2000);
    wr(4'd6, 32'h0000_008D);
    wr(4'd12, 32'h1);
    cyc(0, 1, 0, 2'b10, 32'h2000, 0);
    chk("R8 unarmed B", brkReq, 0);
    cyc(0, 1, 0, 2'b10, 32'h3000, 0);
    chk("R8 A alone", brkReq, 0);
    cyc(0, 1, 0, 2'b10, 32'h2000, 0);
    chk("R8 B after A", brkReq, 1);
    chk("R11 seq uses B timing", brkAfter, 1);
    chk("R12 seq sets A", stsA, 1);
    chk("R12 seq sets B", stsB, 1);
    cyc(0, 1, 0, 2'b10, 32'h2000, 0);
    chk("R8 disarmed after break", brkReq, 0);
    cyc(0, 1, 0, 2'b10, 32'h3000, 0);
    idle();
    wr(4'd9, 32'h0000_FFFF);
    cyc(0, 1, 0, 2'b10, 32'h2000, 0);
    chk("R9 write disarms", brkReq, 0);
    idle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule